// File: doc/BRIEF.md
# Four-State Serial Mealy Detector with Selectable State Encoding

This block is a small Mealy machine that eats one bit per accepted transfer and answers it in the same cycle. It has four states, named A, B, D and E, and starts in A. The machine walks forward on ones and falls back on zeros. It raises its output only when it sits in D or E and the incoming bit is 1. The transition table is fixed and already minimal.

The bits arrive on a valid/ready stream, and the answers leave on a second valid/ready stream with the same beat. A compile-time parameter chooses how the state register is encoded: two-bit binary, two-bit Gray, or four-bit one-hot. Each encoding has its own next-state equations. The output sequence does not depend on the encoding. A debug port shows the raw state register.

Back-pressure rules:
- The input side is ready exactly when the downstream side is ready.
- The output side is valid exactly when the input side is valid.
- A bit is consumed, and the state may move, only in a cycle where `in_valid` and `out_ready` are both high.
- When no transfer happens, the state holds. The output bit still reflects the current state and the presented input bit.

Top module: `seq_mealy_fsm`

## Requirements
- R1: A synchronous active-high `rst` puts the machine in state A at the next rising edge. `dbg_state` then reads 2'b00 for binary and Gray, and 4'b0001 for one-hot.
- R2: On an accepted bit x the state moves as follows. A goes to A on 0 and to B on 1. B goes to B on 0 and to D on 1. D goes to E on 0 and to D on 1. E goes to A on 0 and to D on 1.
- R3: `out_bit` is 1 exactly when the current state is D or E and `in_bit` is 1, in the same cycle. Otherwise it is 0.
- R4: `dbg_state` uses these codes. Binary: A=00, B=01, D=10, E=11. Gray: A=00, B=01, D=11, E=10. One-hot: A=0001, B=0010, D=0100, E=1000.
- R5: `in_ready` equals `out_ready` and `out_valid` equals `in_valid` in every cycle. The state changes only in a cycle where `in_valid` and `out_ready` are both high.
- R6: Starting from A, the accepted stream 0,1,0,1,0,1,1,0,1,0,0 produces the outputs 0,0,0,0,0,1,1,0,1,0,0.
- R7: The binary, Gray and one-hot builds give the same `out_bit` sequence for any input stream and any handshake pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to state A, active high |
| in_valid | input | 1 | Input bit is present |
| in_bit | input | 1 | Serial input bit x |
| in_ready | output | 1 | Block can take the bit (mirrors out_ready) |
| out_valid | output | 1 | Output bit is present (mirrors in_valid) |
| out_bit | output | 1 | Mealy output y for the current state and in_bit |
| out_ready | input | 1 | Downstream accepts the output bit |
| dbg_state | output | 2 (binary, Gray) or 4 (one-hot) | Raw state register |

## Verification
`out_bit`, `out_valid` and `in_ready` are combinational, so they are due in the same cycle the inputs are driven. The bench drives inputs on the falling edge and samples these outputs a little later, before the next rising edge. `dbg_state` is due one rising edge after an accepted bit or after reset. The bench's reference model advances its state only on that edge, and only when both valid and ready were high, so the register value is compared in the following cycle. All three encodings are instanced side by side. The bench checks them against the model and against one another under directed and random streams, with random stalls on either side.

// File: rtl/mfsm_pkg.sv
package mfsm_pkg;

  typedef enum logic [1:0] {
    ENC_BINARY = 2'd0,
    ENC_GRAY   = 2'd1,
    ENC_ONEHOT = 2'd2
  } enc_e;

  // Abstract state index: A=0, B=1, D=2, E=3
  localparam int NUM_STATES = 4;
  localparam int IDX_A = 0;
  localparam int IDX_D = 2;

  function automatic int state_w(enc_e e);
    return (e == ENC_ONEHOT) ? NUM_STATES : 2;
  endfunction

  function automatic logic [3:0] state_code(enc_e e, int idx);
    logic [1:0] b;
    b = idx[1:0];
    case (e)
      ENC_GRAY:   return {2'b00, b[1], b[1] ^ b[0]};
      ENC_ONEHOT: return 4'b0001 << b;
      default:    return {2'b00, b};
    endcase
  endfunction

endpackage

// File: rtl/mfsm_next_bin.sv
module mfsm_next_bin (
  input  logic [1:0] cur,
  input  logic       x,
  output logic [1:0] nxt,
  output logic       y
);
  // A=00 B=01 D=10 E=11
  always_comb begin
    nxt[1] = (x & (cur[1] | cur[0])) | (~x & cur[1] & ~cur[0]);
    nxt[0] = (~x & (cur[1] ^ cur[0])) | (x & ~cur[1] & ~cur[0]);
    y      = x & cur[1];
  end
endmodule

// File: rtl/mfsm_next_gray.sv
module mfsm_next_gray (
  input  logic [1:0] cur,
  input  logic       x,
  output logic [1:0] nxt,
  output logic       y
);
  // A=00 B=01 D=11 E=10
  always_comb begin
    nxt[1] = (x & (cur[1] | cur[0])) | (~x & cur[1] & cur[0]);
    nxt[0] = x | (~cur[1] & cur[0]);
    y      = x & cur[1];
  end
endmodule

// File: rtl/mfsm_next_onehot.sv
module mfsm_next_onehot (
  input  logic [3:0] cur,
  input  logic       x,
  output logic [3:0] nxt,
  output logic       y
);
  // bit0=A bit1=B bit2=D bit3=E
  logic legal;
  logic [3:0] calc;

  always_comb begin
    legal   = (cur != 4'b0000) && ((cur & (cur - 4'd1)) == 4'b0000);
    calc[0] = ~x & (cur[0] | cur[3]);
    calc[1] = (~x & cur[1]) | (x & cur[0]);
    calc[2] = x & (cur[1] | cur[2] | cur[3]);
    calc[3] = ~x & cur[2];
    // any corrupted vector falls back to A
    nxt     = legal ? calc : 4'b0001;
    y       = legal & x & (cur[2] | cur[3]);
  end
endmodule

// File: rtl/seq_mealy_fsm.sv
module seq_mealy_fsm #(
  parameter mfsm_pkg::enc_e ENC = mfsm_pkg::ENC_BINARY
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic out_valid,
  output logic out_bit,
  input  logic out_ready,
  output logic [mfsm_pkg::state_w(ENC)-1:0] dbg_state
);
  import mfsm_pkg::*;

  localparam int SW = state_w(ENC);
  localparam logic [3:0] HOME4 = state_code(ENC, IDX_A);
  localparam logic [3:0] DCODE4 = state_code(ENC, IDX_D);
  localparam logic [SW-1:0] HOME = HOME4[SW-1:0];
  localparam logic [SW-1:0] DCODE = DCODE4[SW-1:0];

  logic [SW-1:0] st_q, st_d;
  logic          y_c;
  logic          fire;

  generate
    if (ENC == ENC_ONEHOT) begin : g_hot
      mfsm_next_onehot u_nx (.cur(st_q), .x(in_bit), .nxt(st_d), .y(y_c));
    end else if (ENC == ENC_GRAY) begin : g_gray
      mfsm_next_gray u_nx (.cur(st_q), .x(in_bit), .nxt(st_d), .y(y_c));
    end else begin : g_bin
      mfsm_next_bin u_nx (.cur(st_q), .x(in_bit), .nxt(st_d), .y(y_c));
    end
  endgenerate

  assign fire      = in_valid & out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign out_bit   = y_c;
  assign dbg_state = st_q;

  always_ff @(posedge clk) begin
    if (rst)       st_q <= HOME;
    else if (fire) st_q <= st_d;
  end

  a_r1_reset_home: assert property (@(posedge clk) rst |=> st_q == HOME);
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(st_q));
  a_r3_zero_on_low: assert property (@(posedge clk) disable iff (rst)
    !in_bit |-> !out_bit);
  a_r2_hit_lands_d: assert property (@(posedge clk) disable iff (rst)
    (fire && out_bit) |=> st_q == DCODE);
  a_r2_home_one_step: assert property (@(posedge clk) disable iff (rst)
    (fire && st_q == HOME && !in_bit) |=> st_q == HOME);

  generate
    if (ENC == ENC_ONEHOT) begin : g_hot_chk
      a_r4_onehot_legal: assert property (@(posedge clk) disable iff (rst)
        $countones(st_q) == 1);
    end
  endgenerate

endmodule

// File: tb/seq_mealy_fsm_tb_top.sv
module seq_mealy_fsm_tb_top;
  import mfsm_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
  logic rdy_b, rdy_g, rdy_h, vld_b, vld_g, vld_h, y_b, y_g, y_h;
  logic [1:0] st_b, st_g;
  logic [3:0] st_h;

  int n_chk = 0, n_bad = 0;
  int ref_st = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seq_mealy_fsm #(.ENC(ENC_BINARY)) dut_i (
    .clk, .rst, .in_valid, .in_bit, .in_ready(rdy_b), .out_valid(vld_b),
    .out_bit(y_b), .out_ready, .dbg_state(st_b));
  seq_mealy_fsm #(.ENC(ENC_GRAY)) dut_gray_i (
    .clk, .rst, .in_valid, .in_bit, .in_ready(rdy_g), .out_valid(vld_g),
    .out_bit(y_g), .out_ready, .dbg_state(st_g));
  seq_mealy_fsm #(.ENC(ENC_ONEHOT)) dut_hot_i (
    .clk, .rst, .in_valid, .in_bit, .in_ready(rdy_h), .out_valid(vld_h),
    .out_bit(y_h), .out_ready, .dbg_state(st_h));

  function automatic logic [3:0] code_of(int enc, int s);
    case (enc)
      1: return {2'b00, s[1], s[1] ^ s[0]};
      2: return 4'b0001 << s;
      default: return s[3:0];
    endcase
  endfunction

  function automatic int step(int s, logic x);
    case (s)
      0: return x ? 1 : 0;
      1: return x ? 2 : 1;
      2: return x ? 2 : 3;
      default: return x ? 2 : 0;
    endcase
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // sample mid-cycle; compares combinational outputs and state to the model
  task automatic compare(string tag);
    logic ey;
    ey = in_bit && (ref_st >= 2);
    chk({tag, " R3 y bin"}, {3'b0, y_b}, {3'b0, ey});
    chk({tag, " R7 y gray"}, {3'b0, y_g}, {3'b0, y_b});
    chk({tag, " R7 y hot"}, {3'b0, y_h}, {3'b0, y_b});
    chk({tag, " R4 bin code"}, {2'b0, st_b}, code_of(0, ref_st));
    chk({tag, " R4 gray code"}, {2'b0, st_g}, code_of(1, ref_st));
    chk({tag, " R2 hot code"}, st_h, code_of(2, ref_st));
    chk({tag, " R5 ready"}, {1'b0, rdy_h, rdy_g, rdy_b}, {1'b0, {3{out_ready}}});
    chk({tag, " R5 valid"}, {1'b0, vld_h, vld_g, vld_b}, {1'b0, {3{in_valid}}});
  endtask

  // reference model advances on the edge
  always @(posedge clk) begin
    if (rst) ref_st <= 0;
    else if (in_valid && out_ready) ref_st <= step(ref_st, in_bit);
  end

  task automatic beat(logic v, logic x, logic r, string tag);
    @(negedge clk);
    in_valid = v; in_bit = x; out_ready = r;
    #2;
    compare(tag);
  endtask

  initial begin
    automatic logic [10:0] seq = 11'b01010110100;
    automatic logic [10:0] exp = 11'b00000110100;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1: after reset all report state A; x=1 in A yields 0
    beat(1'b0, 1'b1, 1'b1, "R1 reset");
    // R6: directed stream, bit 10 first
    for (int i = 10; i >= 0; i--) begin
      @(negedge clk);
      in_valid = 1'b1; in_bit = seq[i]; out_ready = 1'b1;
      #2;
      compare("R6 stream");
      chk("R6 out", {3'b0, y_b}, {3'b0, exp[i]});
    end
    // R5: stalls leave the state untouched
    for (int i = 0; i < 6; i++) beat(i[0], 1'b1, ~i[0], "R5 stall");
    // R7/R2: random streams with random handshakes
    for (int i = 0; i < 3000; i++) begin
      beat(($urandom % 4) != 0, $urandom % 2, ($urandom % 4) != 0, "R7 rand");
      if (i == 1500) begin
        @(negedge clk); rst = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
        #2; compare("R1 midrun");
        chk("R1 midrun state", st_h, 4'b0001);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule